// File: doc/BRIEF.md
# Lane Scrambler and Alignment Character Inserter

This block is the per-lane user-data stage of a serial converter link transmitter. Every beat, each lane takes four octets. The octet in the lowest byte is sent first. While the link is in its user-data phase, each lane scrambles the octets with a self-synchronous scrambler. Some octets fall on the last position of a frame or of a multiframe. When such an octet already equals the matching alignment control code, the lane marks it as a control character so the receiver can use it for alignment. The block sends four octets and four control flags per lane per beat toward the line encoder.

Outside the user-data phase the block is transparent: data and control flags pass through unchanged, one cycle late. The upstream state machine drives the initialization sequences through this path, so they are never scrambled. A lane that is switched off sends the idle control code in every position.

The frame length and the multiframe length are set while the link is outside the user-data phase. The frame length is given as F−1, where F is 1, 2, 4 or 8 octets. The multiframe length is given as F×K−1, and F×K must be a multiple of 4. Two global switches turn off scrambling and alignment insertion.

Top module: `lane_scramble_align`

## Requirements
- R1: While reset is asserted, every output octet is 0x00 and every control flag is 0.
- R2: On an enabled lane with data_phase low, each output octet and its flag equal the input octet and flag from one cycle earlier. Leaving the user-data phase also returns the multiframe position to its start.
- R3: On an enabled lane with data_phase high and scrambling on, the scrambler is applied bit by bit. It takes octet 0 first and bit 7 first within each octet. Each output bit is the input bit XOR the scrambled bits 14 and 15 positions earlier. The scrambler history starts at zero after reset and carries over from beat to beat. The result appears one cycle later.
- R4: In the user-data phase, an octet at the end of a frame that is not the end of the multiframe is flagged as control when its scrambled value is 0xFC. Its value is kept as 0xFC.
- R5: In the user-data phase, the octet at the end of the multiframe is flagged as control when its scrambled value is 0x7C. A 0xFC value in that position is not flagged.
- R6: The multiframe octet index is 4×beat+octet. It restarts at 0 on the first beat of the user-data phase and wraps after (F×K)/4 beats. An octet ends a frame when (index mod F) = F−1, and it ends the multiframe when index = F×K−1. No flag is raised anywhere else.
- R7: With scrambling off, user-data octets pass through unchanged with all control flags 0, and the scrambler history is held.
- R8: With scrambling on and alignment insertion off, octets are scrambled and all control flags are 0.
- R9: A disabled lane outputs 0xBC with the control flag set in all four positions, one cycle after the disable is seen. Its input is ignored and its scrambler history is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_phase | input | 1 | High while the link is in the user-data phase |
| scr_disable | input | 1 | 1 = scrambling off for all lanes |
| repl_disable | input | 1 | 1 = alignment insertion off for all lanes |
| frame_len_m1 | input | FR_W | Octets per frame minus 1 (0, 1, 3 or 7) |
| mf_len_m1 | input | MF_W | Octets per multiframe minus 1 |
| lane_disable | input | LANES | One bit per lane, 1 = lane off |
| in_data | input | 32*LANES | Four octets per lane, lane 0 lowest, octet 0 lowest |
| in_ctrl | input | 4*LANES | Control flag per input octet |
| out_data | output | 32*LANES | Processed octets toward the encoder |
| out_ctrl | output | 4*LANES | Control flag per output octet |

## Verification
A corrupted scrambler history shows up in the very next user-data beat on that lane. Every later octet differs from the model, because the error keeps feeding back through the taps. A wrong multiframe position shows up only when a 0xFC or 0x7C lands near a boundary. The flag then appears on the wrong octet, or is missing, within one multiframe. To keep such errors from hiding, the bench plants these values on purpose at boundary and non-boundary octets, for every frame size.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int OCTETS = 4;
  localparam int OCT_W  = $clog2(OCTETS);
  localparam int BEAT_W = 8 * OCTETS;
  localparam int SCR_W  = 15;
  localparam int TAP_A  = 13;  // 14 bits back
  localparam int TAP_B  = 14;  // 15 bits back

  localparam logic [7:0] K_IDLE   = 8'hBC;
  localparam logic [7:0] K_FRAME  = 8'hFC;
  localparam logic [7:0] K_MFRAME = 8'h7C;

  typedef struct packed {
    logic [SCR_W-1:0]  hist;
    logic [BEAT_W-1:0] dout;
  } scr_res_t;

  // Serial scrambler unrolled over one beat: octet 0 first, MSB first.
  function automatic scr_res_t scramble_beat(input logic [BEAT_W-1:0] din,
                                             input logic [SCR_W-1:0]  hist);
    scr_res_t r;
    logic s;
    r.hist = hist;
    r.dout = '0;
    for (int j = 0; j < OCTETS; j++) begin
      for (int b = 7; b >= 0; b--) begin
        s = din[8*j+b] ^ r.hist[TAP_A] ^ r.hist[TAP_B];
        r.dout[8*j+b] = s;
        r.hist = {r.hist[SCR_W-2:0], s};
      end
    end
    return r;
  endfunction

  // Alignment decision for one octet at a known position.
  function automatic logic align_hit(input logic [7:0] oct,
                                     input logic eof, input logic eomf);
    if (eomf) return oct == K_MFRAME;
    return eof && (oct == K_FRAME);
  endfunction
endpackage

// File: rtl/lsa_mf_tracker.sv
module lsa_mf_tracker
  import lsa_pkg::*;
#(
  parameter int MF_W = 8,
  parameter int FR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_phase,
  input  logic [FR_W-1:0]     frame_len_m1,
  input  logic [MF_W-1:0]     mf_len_m1,
  output logic [OCTETS-1:0]   eof_mask,
  output logic [OCTETS-1:0]   eomf_mask
);
  localparam int CNT_W = MF_W - OCT_W;

  logic [CNT_W-1:0] beat_cnt;
  logic [CNT_W-1:0] beat_last;

  assign beat_last = mf_len_m1[MF_W-1:OCT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   beat_cnt <= '0;
    else if (!data_phase)         beat_cnt <= '0;
    else if (beat_cnt == beat_last) beat_cnt <= '0;
    else                          beat_cnt <= beat_cnt + 1'b1;
  end

  always_comb begin
    logic [MF_W-1:0] idx;
    for (int j = 0; j < OCTETS; j++) begin
      idx = {beat_cnt, OCT_W'(j)};
      eof_mask[j]  = (idx[FR_W-1:0] & frame_len_m1) == frame_len_m1;
      eomf_mask[j] = idx == mf_len_m1;
    end
  end
endmodule

// File: rtl/lsa_lane.sv
module lsa_lane
  import lsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_phase,
  input  logic              scr_on,
  input  logic              repl_on,
  input  logic              lane_on,
  input  logic [OCTETS-1:0] eof_mask,
  input  logic [OCTETS-1:0] eomf_mask,
  input  logic [BEAT_W-1:0] in_data,
  input  logic [OCTETS-1:0] in_ctrl,
  output logic [BEAT_W-1:0] out_data,
  output logic [OCTETS-1:0] out_ctrl
);
  logic [SCR_W-1:0]  hist;
  scr_res_t          nxt;
  logic [BEAT_W-1:0] proc_data;
  logic [OCTETS-1:0] proc_ctrl;

  always_comb begin
    nxt       = scramble_beat(in_data, hist);
    proc_data = scr_on ? nxt.dout : in_data;
    for (int j = 0; j < OCTETS; j++)
      proc_ctrl[j] = scr_on && repl_on &&
                     align_hit(proc_data[8*j +: 8], eof_mask[j], eomf_mask[j]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist     <= '0;
      out_data <= '0;
      out_ctrl <= '0;
    end else begin
      if (data_phase && lane_on && scr_on) hist <= nxt.hist;
      if (!lane_on) begin
        out_data <= {OCTETS{K_IDLE}};
        out_ctrl <= '1;
      end else if (!data_phase) begin
        out_data <= in_data;
        out_ctrl <= in_ctrl;
      end else begin
        out_data <= proc_data;
        out_ctrl <= proc_ctrl;
      end
    end
  end
endmodule

// File: rtl/lane_scramble_align.sv
module lane_scramble_align
  import lsa_pkg::*;
#(
  parameter int LANES = 2,
  parameter int MF_W  = 8,
  parameter int FR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     data_phase,
  input  logic                     scr_disable,
  input  logic                     repl_disable,
  input  logic [FR_W-1:0]          frame_len_m1,
  input  logic [MF_W-1:0]          mf_len_m1,
  input  logic [LANES-1:0]         lane_disable,
  input  logic [BEAT_W*LANES-1:0]  in_data,
  input  logic [OCTETS*LANES-1:0]  in_ctrl,
  output logic [BEAT_W*LANES-1:0]  out_data,
  output logic [OCTETS*LANES-1:0]  out_ctrl
);
  // Position events shared by all lanes, visible to the checker.
  logic [OCTETS-1:0] eof_mask;
  logic [OCTETS-1:0] eomf_mask;

  lsa_mf_tracker #(.MF_W(MF_W), .FR_W(FR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .data_phase(data_phase),
    .frame_len_m1(frame_len_m1), .mf_len_m1(mf_len_m1),
    .eof_mask(eof_mask), .eomf_mask(eomf_mask)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lsa_lane u_lane (
      .clk(clk), .rst_n(rst_n), .data_phase(data_phase),
      .scr_on(!scr_disable), .repl_on(!repl_disable), .lane_on(!lane_disable[l]),
      .eof_mask(eof_mask), .eomf_mask(eomf_mask),
      .in_data(in_data[BEAT_W*l +: BEAT_W]), .in_ctrl(in_ctrl[OCTETS*l +: OCTETS]),
      .out_data(out_data[BEAT_W*l +: BEAT_W]), .out_ctrl(out_ctrl[OCTETS*l +: OCTETS])
    );
  end
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker
  import lsa_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    data_phase,
  input logic                    scr_disable,
  input logic                    repl_disable,
  input logic [LANES-1:0]        lane_disable,
  input logic [BEAT_W*LANES-1:0] in_data,
  input logic [OCTETS*LANES-1:0] in_ctrl,
  input logic [BEAT_W*LANES-1:0] out_data,
  input logic [OCTETS*LANES-1:0] out_ctrl,
  input logic [OCTETS-1:0]       eof_mask,
  input logic [OCTETS-1:0]       eomf_mask
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R6: at most one multiframe end per beat, and it is also a frame end.
  a_r6_single_mf_end: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eomf_mask));
  a_r6_mf_end_is_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    (eomf_mask & ~eof_mask) == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R9: disabled lane emits idle control codes.
    a_r9_idle_on_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(lane_disable[l]) |->
        out_data[BEAT_W*l +: BEAT_W] == {OCTETS{K_IDLE}} &&
        out_ctrl[OCTETS*l +: OCTETS] == '1);
    // R2: transparent outside the user-data phase.
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(data_phase) && !$past(lane_disable[l]) |->
        out_data[BEAT_W*l +: BEAT_W] == $past(in_data[BEAT_W*l +: BEAT_W]) &&
        out_ctrl[OCTETS*l +: OCTETS] == $past(in_ctrl[OCTETS*l +: OCTETS]));
    // R7: no control flags with scrambling off.
    a_r7_no_flag_unscrambled: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(data_phase) && $past(scr_disable) && !$past(lane_disable[l]) |->
        out_ctrl[OCTETS*l +: OCTETS] == '0);
    // R8: no control flags with insertion off.
    a_r8_no_flag_repl_off: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(data_phase) && $past(repl_disable) && !$past(lane_disable[l]) |->
        out_ctrl[OCTETS*l +: OCTETS] == '0);
    for (genvar j = 0; j < OCTETS; j++) begin : g_oct
      // R4/R5: a flagged user-data octet carries one of the two alignment codes.
      a_r4_flag_value: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(data_phase) && !$past(lane_disable[l]) && out_ctrl[OCTETS*l+j] |->
          out_data[BEAT_W*l+8*j +: 8] == K_FRAME || out_data[BEAT_W*l+8*j +: 8] == K_MFRAME);
    end
  end
endmodule

bind lane_scramble_align lsa_checker #(.LANES(LANES)) u_lsa_chk (
  .clk(clk), .rst_n(rst_n), .data_phase(data_phase),
  .scr_disable(scr_disable), .repl_disable(repl_disable),
  .lane_disable(lane_disable), .in_data(in_data), .in_ctrl(in_ctrl),
  .out_data(out_data), .out_ctrl(out_ctrl),
  .eof_mask(eof_mask), .eomf_mask(eomf_mask)
);

// File: tb/lane_scramble_align_test.sv
`timescale 1ns/1ps
module lane_scramble_align_test;
  localparam int LANES = 2;
  localparam int MF_W  = 8;
  localparam int FR_W  = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                  rst_n = 1'b0;
  logic                  data_phase = 1'b0;
  logic                  scr_disable = 1'b0;
  logic                  repl_disable = 1'b0;
  logic [FR_W-1:0]       frame_len_m1 = '0;
  logic [MF_W-1:0]       mf_len_m1 = 8'd7;
  logic [LANES-1:0]      lane_disable = '0;
  logic [32*LANES-1:0]   in_data = '0;
  logic [4*LANES-1:0]    in_ctrl = '0;
  logic [32*LANES-1:0]   out_data;
  logic [4*LANES-1:0]    out_ctrl;

  lane_scramble_align #(.LANES(LANES), .MF_W(MF_W), .FR_W(FR_W)) uut (
    .clk(clk), .rst_n(rst_n), .data_phase(data_phase),
    .scr_disable(scr_disable), .repl_disable(repl_disable),
    .frame_len_m1(frame_len_m1), .mf_len_m1(mf_len_m1),
    .lane_disable(lane_disable), .in_data(in_data), .in_ctrl(in_ctrl),
    .out_data(out_data), .out_ctrl(out_ctrl)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  bit  hist [LANES][$];      // scrambled bit history per lane, newest last
  int  pos = 0;              // beat index within the multiframe
  logic [31:0] exp_d [LANES];
  logic [3:0]  exp_c [LANES];
  string       exp_tag [LANES];

  // settings applied on the next driven beat
  bit nx_scr_dis = 0, nx_repl_dis = 0;
  int nx_f = 1, nx_m = 8;
  logic [LANES-1:0] nx_lane_dis = '0;

  task automatic check_outputs();
    for (int l = 0; l < LANES; l++) begin
      n_chk++;
      if (out_data[32*l +: 32] !== exp_d[l] || out_ctrl[4*l +: 4] !== exp_c[l]) begin
        n_fail++;
        $display("FAIL %s lane %0d: data %h ctrl %b, expected data %h ctrl %b",
                 exp_tag[l], l, out_data[32*l +: 32], out_ctrl[4*l +: 4], exp_d[l], exp_c[l]);
      end
    end
  endtask

  task automatic drive_beat(input bit phase, input bit plant);
    int f, m;
    scr_disable  = nx_scr_dis;
    repl_disable = nx_repl_dis;
    frame_len_m1 = FR_W'(nx_f - 1);
    mf_len_m1    = MF_W'(nx_m - 1);
    lane_disable = nx_lane_dis;
    data_phase   = phase;
    f = nx_f; m = nx_m;
    for (int l = 0; l < LANES; l++) begin
      logic [31:0] d;
      logic [3:0]  c;
      bit hit_a, hit_f, odd_spot;
      hit_a = 0; hit_f = 0; odd_spot = 0;
      c = 4'($urandom);
      for (int j = 0; j < 4; j++) begin
        int idx, pick;
        bit eof, eomf, hit;
        logic [7:0] tgt, din, sout;
        idx  = pos * 4 + j;
        eof  = (idx % f) == f - 1;
        eomf = idx == m - 1;
        pick = plant ? $urandom_range(0, 3) : 3;
        tgt  = (pick == 0) ? 8'hFC : (pick == 1) ? 8'h7C : 8'($urandom);
        if (!phase || lane_disable[l] || scr_disable) begin
          din = tgt; sout = tgt;
        end else begin
          for (int b = 7; b >= 0; b--) begin
            bit taps;
            taps = hist[l][hist[l].size()-14] ^ hist[l][hist[l].size()-15];
            din[b]  = (pick < 2) ? (tgt[b] ^ taps) : tgt[b];
            sout[b] = din[b] ^ taps;
            hist[l].push_back(sout[b]);
            void'(hist[l].pop_front());
          end
        end
        d[8*j +: 8] = din;
        if (lane_disable[l]) begin
          exp_d[l][8*j +: 8] = 8'hBC; exp_c[l][j] = 1'b1;
        end else if (!phase) begin
          exp_d[l][8*j +: 8] = din; exp_c[l][j] = c[j];
        end else begin
          hit = !scr_disable && !repl_disable &&
                (eomf ? (sout == 8'h7C) : (eof && sout == 8'hFC));
          exp_d[l][8*j +: 8] = sout; exp_c[l][j] = hit;
          if (hit && eomf) hit_a = 1;
          if (hit && !eomf) hit_f = 1;
          if (!hit && (sout == 8'hFC || sout == 8'h7C)) odd_spot = 1;
        end
      end
      in_data[32*l +: 32] = d;
      in_ctrl[4*l +: 4]   = c;
      exp_tag[l] = lane_disable[l] ? "R9" : !phase ? "R2" : scr_disable ? "R7" :
                   repl_disable ? "R8" : hit_a ? "R5" : hit_f ? "R4" :
                   odd_spot ? "R6" : "R3";
    end
    pos = phase ? (pos + 1) % (m / 4) : 0;
  endtask

  task automatic step(input bit phase, input bit plant);
    @(negedge clk);
    check_outputs();
    drive_beat(phase, plant);
  endtask

  task automatic run_cfg(input int f, input int m, input bit sd, input bit rd,
                         input logic [LANES-1:0] ld, input int beats);
    nx_f = f; nx_m = m; nx_scr_dis = sd; nx_repl_dis = rd; nx_lane_dis = ld;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);   // R2 between phases
    for (int i = 0; i < beats; i++) step(1'b1, 1'b1);
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin
      for (int k = 0; k < 15; k++) hist[l].push_back(1'b0);
      exp_d[l] = '0; exp_c[l] = '0; exp_tag[l] = "R1";
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_outputs();                                 // R1 reset state
    end
    rst_n = 1'b1;
    drive_beat(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0);      // R2 transparency
    run_cfg(1, 8,  0, 0, '0, 60);                      // R6 F=1
    run_cfg(2, 16, 0, 0, '0, 60);                      // R6 F=2
    run_cfg(4, 32, 0, 0, '0, 60);                      // R6 F=4
    run_cfg(8, 64, 0, 0, '0, 60);                      // R6 F=8
    run_cfg(2, 8,  0, 0, '0, 40);                      // R4/R5 short multiframe
    run_cfg(4, 16, 1, 1, '0, 30);                      // R7 scrambling off
    run_cfg(4, 16, 0, 1, '0, 30);                      // R8 insertion off
    run_cfg(4, 16, 0, 0, 2'b10, 30);                   // R9 lane 1 off
    run_cfg(4, 16, 0, 0, '0, 30);                      // R3 history held through R9
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, got hang, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule